// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block runs the multi-register load and store operation of a small processor core. A start pulse hands it a 16-bit mask that selects registers, the index of the register that holds the base address, a load-or-store select and a write-back enable. It then makes one word access for each selected register. Registers are taken lowest index first, and the address begins at the base value and rises by four on each access. Loaded words go into a 16-entry register file that lives inside the block. The core reaches that file through a simple read port and write port. The updated base can be written back into it.

Aborts are treated differently for the two directions. A store keeps issuing every bus cycle and changes nothing except the base write-back. A load stops writing registers from the aborting access onward, and at the end it repairs the base register. In both cases the trap flag goes high together with `done`, and never earlier.

The controller is one state machine with these states:
- `ST_IDLE`: waiting; core register access is allowed.
- `ST_SETUP`: the address cycle.
- `ST_XFER`: one cycle for each selected register.
- `ST_LD_INT`: the internal cycle that ends a load.
- `ST_PC_SEQ` and `ST_PC_NONSEQ`: the refill cycles added when the top register is loaded.
- `ST_FIN`: the single-cycle end of an illegal or empty request.

Transitions:
- `ST_IDLE` goes to `ST_SETUP` on start, or to `ST_FIN` if the base is illegal or the mask is empty.
- `ST_SETUP` goes to `ST_XFER`.
- `ST_XFER` stays in `ST_XFER` until the last transfer. It then goes to `ST_LD_INT` for a load, or to `ST_IDLE` for a store.
- `ST_LD_INT` goes to `ST_PC_SEQ` if the top register was in the mask, otherwise to `ST_IDLE`.
- `ST_PC_SEQ` goes to `ST_PC_NONSEQ`, which goes to `ST_IDLE`.
- `ST_FIN` goes to `ST_IDLE`.

Top module: `blk_xfer_seq`

## Requirements
- R1: When idle, `start` is accepted on a clock edge and `busy` is high from the next cycle. While busy, `start` and the other request inputs are ignored. `done` is high for exactly the final cycle of the operation, and the block is idle in the cycle after.
- R2: Each set mask bit produces exactly one access (`mem_req` high), in ascending register index. The k-th access (k from 0) uses address base+4k. `mem_we` is 1 for a store and 0 for a load. The updated base is base + 4 × (number of set mask bits).
- R3: With write-back enabled, the updated base is written into the base register at the end of the operation's second cycle, which is its first transfer cycle.
- R4: Store data is driven during the access cycle itself. When the base register is first in transfer order, its original value is stored. When it is second or later and write-back is on, the updated value is stored.
- R5: A load whose mask includes the base register leaves the loaded word in that register, not the written-back value, when no abort occurs.
- R6: `mem_abort` is sampled on every access. It never shortens the sequence. If any access aborted, `abort_trap` is high in the `done` cycle, and it is low otherwise.
- R7: After a store abort, all remaining accesses are still issued. The only register file change is the base write-back when it is enabled.
- R8: After a load abort, the aborting access and all later accesses write no register. Registers loaded before the abort keep their new values. Register 15, always loaded last, therefore stays unchanged.
- R9: After a load abort, the base register ends at the updated base if write-back was enabled, and at the original base otherwise, even when a load overwrote it first.
- R10: `cyc_type` encodes 0 = sequential, 1 = non-sequential, 2 = internal, and shows 2 when idle.
  - A load of n words shows N, then n × S, then I.
  - If register 15 is in the load mask, S and N follow after that.
  - A store of n words shows N, then (n−1) × S, then N.
- R11: A base index of 15 makes the operation end in a single cycle with `done` and `illegal` high, no access, cycle type 2, and no register change. This takes precedence over an empty mask.
- R12: An empty mask with a legal base ends in a single cycle with `done` high, `illegal` low, no access and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears state and register file |
| start | input | 1 | Request pulse, sampled while idle |
| reg_mask | input | 16 | Register selection mask |
| base_sel | input | 4 | Index of the base register |
| load_sel | input | 1 | 1 = load from memory, 0 = store to memory |
| wb_en | input | 1 | Write the updated base back |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| illegal | output | 1 | Base index 15 was requested (with done) |
| abort_trap | output | 1 | An access aborted (with done) |
| cyc_type | output | 2 | Cycle kind: 0 S, 1 N, 2 I |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid in the access cycle |
| mem_abort | input | 1 | Abort for the current access |
| core_we | input | 1 | Core register write, honoured while idle |
| core_widx | input | 4 | Core write index |
| core_wdata | input | 32 | Core write data |
| core_ridx | input | 4 | Core read index |
| core_rdata | output | 32 | Core read data, combinational |

## Verification
The bench builds the block with its defaults: 16 registers and 32-bit words. This makes the top register (index 15) both the illegal base and the register that adds the refill cycles, so both cases are reachable with real masks. Sixteen entries also let a mask place the base first, in the middle, or ahead of an abort, and let an abort land exactly on the top register's load.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    typedef enum logic [1:0] {
        CT_SEQ    = 2'd0,
        CT_NONSEQ = 2'd1,
        CT_INT    = 2'd2
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_LD_INT,
        ST_PC_SEQ,
        ST_PC_NONSEQ,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/xfer_regfile.sv
// Register file with two write ports (port B wins on the same index)
// and two combinational read ports.
module xfer_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  logic [DW-1:0] a_data,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  logic [DW-1:0] b_data,
    input  logic [IW-1:0] r0_idx,
    output logic [DW-1:0] r0_data,
    input  logic [IW-1:0] r1_idx,
    output logic [DW-1:0] r1_data
);

    logic [DW-1:0] word [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (b_we && b_idx == IW'(g)) begin
                q <= b_data;
            end else if (a_we && a_idx == IW'(g)) begin
                q <= a_data;
            end
        end
        assign word[g] = q;
    end

    assign r0_data = word[r0_idx];
    assign r1_data = word[r1_idx];

endmodule

// File: rtl/xfer_lowest.sv
// Finds the lowest set bit of a mask and returns the mask without it.
module xfer_lowest #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  rest
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
        rest = mask & ~({{(N-1){1'b0}}, 1'b1} << idx);
    end

endmodule

// File: rtl/xfer_popcnt.sv
// Counts the set bits of a mask.
module xfer_popcnt #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  mask,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(mask[i]);
        end
    end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NREG-1:0]          reg_mask,
    input  logic [$clog2(NREG)-1:0]  base_sel,
    input  logic                     load_sel,
    input  logic                     wb_en,
    output logic                     busy,
    output logic                     done,
    output logic                     illegal,
    output logic                     abort_trap,
    output logic [1:0]               cyc_type,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [DW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_abort,
    input  logic                     core_we,
    input  logic [$clog2(NREG)-1:0]  core_widx,
    input  logic [DW-1:0]            core_wdata,
    input  logic [$clog2(NREG)-1:0]  core_ridx,
    output logic [DW-1:0]            core_rdata
);

    localparam int IW       = $clog2(NREG);
    localparam int CW       = $clog2(NREG + 1);
    localparam int SHIFT    = $clog2(DW / 8);
    localparam int STEP     = DW / 8;
    localparam int TOP      = NREG - 1;
    localparam logic [IW-1:0] BAD_BASE = IW'(TOP);

    seq_state_t      state_q, state_d;
    logic [NREG-1:0] rem_q;
    logic            top_q;
    logic [IW-1:0]   base_q;
    logic            load_q;
    logic            wb_q;
    logic            ill_q;
    logic            first_q;
    logic            ab_q;
    logic [DW-1:0]   orig_q;
    logic [DW-1:0]   newb_q;
    logic [DW-1:0]   addr_q;

    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] rem_rest;
    logic            last_xfer;
    logic [CW-1:0]   pop_cnt;
    logic [IW-1:0]   seq_ridx;
    logic [DW-1:0]   seq_rdata;

    logic            a_we, b_we;
    logic [IW-1:0]   a_idx, b_idx;
    logic [DW-1:0]   a_data, b_data;
    cyc_kind_t       kind;

    xfer_lowest #(.N(NREG), .IW(IW)) i_lowest (
        .mask (rem_q),
        .idx  (cur_idx),
        .rest (rem_rest)
    );

    xfer_popcnt #(.N(NREG), .CW(CW)) i_popcnt (
        .mask (reg_mask),
        .cnt  (pop_cnt)
    );

    xfer_regfile #(.NREG(NREG), .DW(DW), .IW(IW)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (a_we),
        .a_idx   (a_idx),
        .a_data  (a_data),
        .b_we    (b_we),
        .b_idx   (b_idx),
        .b_data  (b_data),
        .r0_idx  (core_ridx),
        .r0_data (core_rdata),
        .r1_idx  (seq_ridx),
        .r1_data (seq_rdata)
    );

    assign last_xfer = (rem_rest == '0);
    assign seq_ridx  = (state_q == ST_IDLE) ? base_sel : cur_idx;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = (base_sel == BAD_BASE || reg_mask == '0)
                                               ? ST_FIN : ST_SETUP;
            ST_SETUP:     state_d = ST_XFER;
            ST_XFER:      if (last_xfer) state_d = load_q ? ST_LD_INT : ST_IDLE;
            ST_LD_INT:    state_d = top_q ? ST_PC_SEQ : ST_IDLE;
            ST_PC_SEQ:    state_d = ST_PC_NONSEQ;
            ST_PC_NONSEQ: state_d = ST_IDLE;
            ST_FIN:       state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            top_q   <= 1'b0;
            base_q  <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
            ill_q   <= 1'b0;
            first_q <= 1'b0;
            ab_q    <= 1'b0;
            orig_q  <= '0;
            newb_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                rem_q   <= reg_mask;
                top_q   <= reg_mask[TOP];
                base_q  <= base_sel;
                load_q  <= load_sel;
                wb_q    <= wb_en;
                ill_q   <= (base_sel == BAD_BASE);
                first_q <= 1'b1;
                ab_q    <= 1'b0;
                orig_q  <= seq_rdata;
                newb_q  <= seq_rdata + (DW'(pop_cnt) << SHIFT);
                addr_q  <= seq_rdata;
            end else if (state_q == ST_XFER) begin
                rem_q   <= rem_rest;
                addr_q  <= addr_q + DW'(STEP);
                first_q <= 1'b0;
                if (mem_abort) ab_q <= 1'b1;
            end
        end
    end

    // Outputs and register file write control
    always_comb begin
        kind      = CT_INT;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = seq_rdata;
        a_we      = 1'b0;
        a_idx     = base_q;
        a_data    = newb_q;
        b_we      = 1'b0;
        b_idx     = cur_idx;
        b_data    = mem_rdata;
        unique case (state_q)
            ST_IDLE: begin
                b_we   = core_we;
                b_idx  = core_widx;
                b_data = core_wdata;
            end
            ST_SETUP: kind = CT_NONSEQ;
            ST_XFER: begin
                mem_req = 1'b1;
                mem_we  = !load_q;
                kind    = (!load_q && last_xfer) ? CT_NONSEQ : CT_SEQ;
                done    = !load_q && last_xfer;
                a_we    = first_q && wb_q;
                b_we    = load_q && !ab_q && !mem_abort;
            end
            ST_LD_INT: begin
                done   = !top_q;
                a_we   = ab_q;
                a_data = wb_q ? newb_q : orig_q;
            end
            ST_PC_SEQ:    kind = CT_SEQ;
            ST_PC_NONSEQ: begin
                kind = CT_NONSEQ;
                done = 1'b1;
            end
            ST_FIN:  done = 1'b1;
            default: kind = CT_INT;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign cyc_type   = kind;
    assign illegal    = (state_q == ST_FIN) && ill_q;
    assign abort_trap = done && (ab_q || (state_q == ST_XFER && mem_abort));

endmodule

// File: rtl/xfer_seq_checker.sv
module xfer_seq_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic          abort_trap,
    input logic [1:0]    cyc_type,
    input logic          mem_req,
    input logic [DW-1:0] mem_addr,
    input logic          mem_abort
);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    p_done_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + DW'(DW / 8));

    p_trap_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_trap |-> done);

    p_abort_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_abort && !done |=> busy);

    p_access_not_internal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cyc_type != 2'd2);

    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !mem_req && cyc_type == 2'd2);

endmodule

bind blk_xfer_seq xfer_seq_checker #(.DW(DW)) i_xfer_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .abort_trap (abort_trap),
    .cyc_type   (cyc_type),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_abort  (mem_abort)
);

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

    localparam int NREG = 16;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [15:0]   reg_mask;
    logic [3:0]    base_sel;
    logic          load_sel;
    logic          wb_en;
    logic          busy, done, illegal, abort_trap;
    logic [1:0]    cyc_type;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr, mem_wdata, mem_rdata;
    logic          mem_abort;
    logic          core_we;
    logic [3:0]    core_widx, core_ridx;
    logic [31:0]   core_wdata, core_rdata;

    logic          ab_en;
    logic [31:0]   ab_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_rf [16];

    always #5 clk = ~clk;

    assign mem_rdata = {16'hC0DE, mem_addr[15:0]};
    assign mem_abort = ab_en && mem_req && (mem_addr == ab_addr);

    blk_xfer_seq #(.NREG(NREG), .DW(DW)) i_blk_xfer_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .reg_mask   (reg_mask),
        .base_sel   (base_sel),
        .load_sel   (load_sel),
        .wb_en      (wb_en),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .abort_trap (abort_trap),
        .cyc_type   (cyc_type),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_abort  (mem_abort),
        .core_we    (core_we),
        .core_widx  (core_widx),
        .core_wdata (core_wdata),
        .core_ridx  (core_ridx),
        .core_rdata (core_rdata)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int i, input logic [31:0] v);
        @(negedge clk);
        core_we = 1'b1; core_widx = i[3:0]; core_wdata = v;
        @(negedge clk);
        core_we = 1'b0;
        exp_rf[i] = v;
    endtask

    task automatic chk_rf(input string tag);
        for (int i = 0; i < 16; i++) begin
            core_ridx = i[3:0];
            #1;
            chk(core_rdata == exp_rf[i], tag, core_rdata, exp_rf[i]);
        end
    endtask

    // Runs one operation and checks every observable effect against a model
    task automatic run_op(input logic [15:0] mask, input int base, input bit ld,
                          input bit wb, input bit ab_on, input int ab_k,
                          input bit spur, input string tag);
        logic [31:0] b, newb;
        int idx_list [16];
        int n, exp_len, act_len, nacc, bad_at;
        logic [1:0] exp_ct [64];
        logic [1:0] act_ct [64];
        logic [31:0] acc_addr [64];
        logic [31:0] acc_data [64];
        logic        acc_we [64];
        bit fin, ill, empty, got_trap, got_ill;
        n = 0;
        for (int i = 0; i < 16; i++) if (mask[i]) begin idx_list[n] = i; n++; end
        b     = exp_rf[base];
        newb  = b + 32'(4 * n);
        ill   = (base == 15);
        empty = (mask == 16'h0);
        exp_len = 0;
        if (ill || empty) begin
            exp_ct[0] = 2'd2; exp_len = 1;
        end else if (ld) begin
            exp_ct[exp_len++] = 2'd1;
            for (int k = 0; k < n; k++) exp_ct[exp_len++] = 2'd0;
            exp_ct[exp_len++] = 2'd2;
            if (mask[15]) begin exp_ct[exp_len++] = 2'd0; exp_ct[exp_len++] = 2'd1; end
        end else begin
            exp_ct[exp_len++] = 2'd1;
            for (int k = 0; k < n - 1; k++) exp_ct[exp_len++] = 2'd0;
            exp_ct[exp_len++] = 2'd1;
        end
        ab_en   = ab_on;
        ab_addr = b + 32'(4 * ab_k);
        @(negedge clk);
        reg_mask = mask; base_sel = base[3:0]; load_sel = ld; wb_en = wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fin = 0; nacc = 0; act_len = 0; got_trap = 0; got_ill = 0;
        for (int cyc = 0; cyc < 64; cyc++) begin
            act_ct[cyc] = cyc_type;
            if (mem_req) begin
                acc_addr[nacc] = mem_addr; acc_data[nacc] = mem_wdata;
                acc_we[nacc] = mem_we; nacc++;
            end
            if (spur && cyc == 1) begin start = 1'b1; reg_mask = 16'hFFFF; end
            if (spur && cyc == 2) start = 1'b0;
            if (done) begin
                got_trap = abort_trap; got_ill = illegal; act_len = cyc + 1; fin = 1;
                break;
            end
            @(negedge clk);
        end
        chk(fin, {tag, " R1 done seen"}, 32'(fin), 32'd1);
        @(negedge clk);
        chk(!busy, "R1 idle after done", 32'(busy), 32'd0);
        ab_en = 1'b0;
        // R10 cycle-type sequence
        chk(act_len == exp_len, "R10 cycle count", 32'(act_len), 32'(exp_len));
        bad_at = -1;
        for (int c = 0; c < exp_len && c < act_len; c++)
            if (bad_at < 0 && act_ct[c] != exp_ct[c]) bad_at = c;
        chk(bad_at < 0, "R10 cycle kind sequence",
            (bad_at < 0) ? 32'd0 : 32'(act_ct[bad_at]),
            (bad_at < 0) ? 32'd0 : 32'(exp_ct[bad_at]));
        // R2 accesses
        chk(nacc == ((ill || empty) ? 0 : n), "R2 access count", 32'(nacc),
            32'((ill || empty) ? 0 : n));
        if (!(ill || empty)) begin
            for (int k = 0; k < n && k < nacc; k++) begin
                chk(acc_addr[k] == b + 32'(4 * k), "R2 address", acc_addr[k], b + 32'(4 * k));
                chk(acc_we[k] == !ld, "R2 direction", 32'(acc_we[k]), 32'(!ld));
                if (!ld) begin
                    logic [31:0] ev;
                    ev = (idx_list[k] == base && wb && k > 0) ? newb : exp_rf[idx_list[k]];
                    chk(acc_data[k] == ev, "R4 store data", acc_data[k], ev);
                end
            end
        end
        chk(got_trap == (ab_on && !(ill || empty)), "R6 abort trap",
            32'(got_trap), 32'(ab_on && !(ill || empty)));
        chk(got_ill == ill, "R11 illegal flag", 32'(got_ill), 32'(ill));
        // Register file model
        if (!(ill || empty)) begin
            if (wb) exp_rf[base] = newb;
            if (ld) begin
                for (int k = 0; k < n; k++)
                    if (!(ab_on && k >= ab_k))
                        exp_rf[idx_list[k]] = {16'hC0DE, 16'(b + 32'(4 * k))};
                if (ab_on) exp_rf[base] = wb ? newb : b;
            end
        end
        chk_rf(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; reg_mask = '0; base_sel = '0; load_sel = 1'b0;
        wb_en = 1'b0; core_we = 1'b0; core_widx = '0; core_wdata = '0; core_ridx = '0;
        ab_en = 1'b0; ab_addr = '0;
        for (int i = 0; i < 16; i++) exp_rf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R10)
        chk(!busy && !done && !mem_req, "R1 reset idle", {29'd0, busy, done, mem_req}, 32'd0);
        chk(cyc_type == 2'd2, "R10 idle kind", 32'(cyc_type), 32'd2);
        core_ridx = 4'd5; #1;
        chk(core_rdata == 32'd0, "R1 reset register", core_rdata, 32'd0);

        for (int i = 0; i < 16; i++) wr_reg(i, 32'h1000_0000 + 32'(i * 32'h111));
        wr_reg(2, 32'h0000_2000);
        wr_reg(5, 32'h0000_4000);
        wr_reg(6, 32'h0000_6000);
        wr_reg(4, 32'h0000_8000);

        run_op(16'h0034, 2, 0, 1, 0, 0, 0, "R3 store base first");
        run_op(16'h0222, 5, 0, 1, 0, 0, 0, "R4 store base second");
        run_op(16'h00F0, 2, 1, 1, 0, 0, 0, "R3 load write-back");
        run_op(16'h0070, 5, 1, 1, 0, 0, 0, "R5 load base in list");
        run_op(16'h8003, 3, 1, 0, 0, 0, 0, "R10 load top register");
        run_op(16'h0F00, 2, 0, 1, 1, 1, 0, "R7 store abort");
        run_op(16'h0007, 1, 0, 1, 1, 0, 0, "R7 store abort first");
        wr_reg(6, 32'h0000_6000);
        run_op(16'hC0C0, 6, 1, 1, 1, 2, 0, "R9 load abort wb");
        wr_reg(4, 32'h0000_8000);
        run_op(16'h8013, 4, 1, 0, 1, 3, 0, "R8 load abort top");
        run_op(16'h00FF, 15, 1, 1, 0, 0, 0, "R11 illegal base");
        run_op(16'h0000, 2, 0, 1, 0, 0, 0, "R12 empty mask");
        run_op(16'h0E00, 1, 0, 0, 0, 0, 1, "R1 start ignored while busy");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule